// File: doc/BRIEF.md
# MSI Coherence Controller for a Directory-Based Memory System

This block sits between one processor and its private direct-mapped cache in a distributed-memory machine. There is no shared broadcast bus. Every coherence action is a point-to-point message exchanged with the home directory. On a processor miss or on a write to a line held only for reading, the controller marks the line invalid and sends a single request to the directory. If the displaced line was dirty, the controller first sends its data back. It then stalls the processor until the directory returns the block. The cache line ends in Shared after a read and in Modified after a write.

The controller also serves commands that the directory starts. It services them while idle and also while it waits for its own response:
- A downgrade command makes the controller return a dirty block and keep a read-only copy.
- A downgrade-and-drop command makes it return a dirty block and give up the line.
- A plain invalidate command removes a read-only copy.

Each message carries a 3-bit opcode, a word address and a data word. Lines are one word wide. The line index is the low address bits and the tag is the rest.

Top module: `cc_msi_ctrl`

## Requirements
- R1: A read to a line that is not present sends a read request (opcode 1) carrying the processor address. When a data response (opcode 0) for that address arrives, the line is filled in Shared and the read completes with the response data.
- R2: A write to a line held in Shared sends an upgrade request (opcode 3) for that address. When the data response arrives, the line becomes Modified and holds the processor's write data.
- R3: A write to a line that is not present sends a write request (opcode 2). When the response arrives, the line becomes Modified and holds the processor's write data.
- R4: When a miss displaces a Modified line of a different tag, a writeback (opcode 4) goes out first, carrying the victim's address and data, and the new request follows. A displaced Shared line produces no message.
- R5: A downgrade command (opcode 5) for a Modified line produces a writeback of its address and data, and the line stays readable in Shared. A later write to it therefore needs an upgrade request.
- R6: A downgrade-and-drop command (opcode 6) for a Modified line produces a writeback of its address and data, and the line becomes Invalid.
- R7: An invalidate command (opcode 7) for a Shared line makes it Invalid. A downgrade command aimed at a Shared line produces no message and no change. A directory command whose tag does not match the resident line also produces no message and no change.
- R8: From a miss until a data response whose address equals the request address, the processor sees no completion. A response carrying any other address is ignored.
- R9: A read of a present line, or a write of a Modified line, completes in the same cycle the request is presented. It sends no message, and the read returns the stored word.
- R10: Once the outgoing channel shows a message, that message stays valid and unchanged until it is accepted, and its opcode is one of 1, 2, 3 or 4.
- R11: Directory commands are accepted while the controller waits for a response. A writeback they cause goes out before the pending response is taken. The controller applies at most one line update per cycle.
- R12: After reset every line is Invalid, the outgoing channel is idle and the incoming channel is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present; held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address of the request |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Request completes at this clock edge |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone |
| outValid | output | 1 | Message to the directory present |
| outReady | input | 1 | Directory accepts the outgoing message |
| outOp | output | 3 | Outgoing opcode: 1 read, 2 write, 3 upgrade, 4 writeback |
| outAddr | output | ADDR_W | Outgoing message address |
| outData | output | DATA_W | Writeback data (zero for requests) |
| inValid | input | 1 | Message from the directory present |
| inReady | output | 1 | Controller accepts the incoming message |
| inOp | input | 3 | Incoming opcode: 0 response, 5 downgrade, 6 downgrade-and-drop, 7 invalidate |
| inAddr | input | ADDR_W | Incoming message address |
| inData | input | DATA_W | Response data |

## Verification
The assertions check four properties on every cycle:
- a stalled outgoing message holds still and carries a legal opcode;
- no completion reaches the processor while a response with a matching address is outstanding;
- a completion only happens against a live request;
- the line arrays never take two updates in one cycle.

The resulting line states cannot be seen at the ports directly, so the bench scenarios show them through follow-up accesses. A line left Shared shows up as a silent read hit followed by an upgrade on write. A line left Invalid shows up as a fresh read request. The bench also checks the ordering of a victim writeback ahead of its request, and a directory command serviced in the middle of a pending miss.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } lineSt_t;

  // message opcodes (3-bit field on both channels)
  localparam logic [2:0] MSG_DRESP    = 3'd0;
  localparam logic [2:0] MSG_RDREQ    = 3'd1;
  localparam logic [2:0] MSG_WRREQ    = 3'd2;
  localparam logic [2:0] MSG_UPGR     = 3'd3;
  localparam logic [2:0] MSG_WBACK    = 3'd4;
  localparam logic [2:0] MSG_FETCH    = 3'd5;
  localparam logic [2:0] MSG_FETCHINV = 3'd6;
  localparam logic [2:0] MSG_INV      = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic cpuWr;      // store processor write data into the hit line
    logic launch;     // capture request, victim, invalidate the indexed line
    logic fill;       // install response data for the pending request
    logic dirDown;    // directory line goes to Shared
    logic dirKill;    // directory line goes to Invalid
    logic dirCapture; // copy directory line into the writeback register
    logic sendWb;     // outgoing channel shows the writeback register
  } ctlStrobe_t;

endpackage

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  ctlStrobe_t        strobe,
  output logic              cpuHit,
  output logic              victimDirty,
  output logic              dirHasMod,
  output logic              dirHasShr,
  output logic              respMatch,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [2:0]        outOp,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  lineSt_t           lineSt   [LINES];
  logic [TAG_W-1:0]  lineTag  [LINES];
  logic [DATA_W-1:0] lineData [LINES];

  logic [ADDR_W-1:0] reqAddr;
  logic [2:0]        reqOp;
  logic              reqWrite;
  logic [ADDR_W-1:0] wbAddr;
  logic [DATA_W-1:0] wbData;

  logic [IDX_W-1:0] cIdx, iIdx, rIdx;
  logic [TAG_W-1:0] cTag, iTag;
  logic             cTagEq, iTagEq;

  assign cIdx = cpuAddr[IDX_W-1:0];
  assign cTag = cpuAddr[ADDR_W-1:IDX_W];
  assign iIdx = inAddr[IDX_W-1:0];
  assign iTag = inAddr[ADDR_W-1:IDX_W];
  assign rIdx = reqAddr[IDX_W-1:0];

  assign cTagEq = (lineTag[cIdx] == cTag);
  assign iTagEq = (lineTag[iIdx] == iTag);

  // processor side lookup
  always_comb begin
    cpuHit = 1'b0;
    if (cTagEq) begin
      if (cpuWrite) cpuHit = (lineSt[cIdx] == LN_MOD);
      else          cpuHit = (lineSt[cIdx] != LN_INV);
    end
  end

  assign victimDirty = (lineSt[cIdx] == LN_MOD) && !cTagEq;
  assign cpuRdata    = lineData[cIdx];

  // directory side lookup
  assign dirHasMod = iTagEq && (lineSt[iIdx] == LN_MOD);
  assign dirHasShr = iTagEq && (lineSt[iIdx] == LN_SHR);
  assign respMatch = (inAddr == reqAddr);

  // line state array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) lineSt[i] <= LN_INV;
    end else begin
      if (strobe.launch)  lineSt[cIdx] <= LN_INV;
      if (strobe.fill)    lineSt[rIdx] <= reqWrite ? LN_MOD : LN_SHR;
      if (strobe.dirDown) lineSt[iIdx] <= LN_SHR;
      if (strobe.dirKill) lineSt[iIdx] <= LN_INV;
    end
  end

  // tag and data arrays
  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      lineTag[rIdx]  <= reqAddr[ADDR_W-1:IDX_W];
      lineData[rIdx] <= inData;
    end
    if (strobe.cpuWr) lineData[cIdx] <= cpuWdata;
  end

  // pending request and writeback registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqOp    <= MSG_RDREQ;
      reqWrite <= 1'b0;
      wbAddr   <= '0;
      wbData   <= '0;
    end else begin
      if (strobe.launch) begin
        reqAddr  <= cpuAddr;
        reqWrite <= cpuWrite;
        if (!cpuWrite)                                reqOp <= MSG_RDREQ;
        else if (cTagEq && lineSt[cIdx] == LN_SHR)    reqOp <= MSG_UPGR;
        else                                          reqOp <= MSG_WRREQ;
        wbAddr <= {lineTag[cIdx], cIdx};
        wbData <= lineData[cIdx];
      end
      if (strobe.dirCapture) begin
        wbAddr <= inAddr;
        wbData <= lineData[iIdx];
      end
    end
  end

  // outgoing message select
  assign outOp   = strobe.sendWb ? MSG_WBACK : reqOp;
  assign outAddr = strobe.sendWb ? wbAddr : reqAddr;
  assign outData = strobe.sendWb ? wbData : '0;

  AST_ONE_LINE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cpuWr, strobe.launch, strobe.fill, strobe.dirDown, strobe.dirKill})) // R11
    else $error("more than one line update in a cycle");

endmodule

// File: rtl/cc_control.sv
module cc_control
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       cpuHit,
  input  logic       victimDirty,
  input  logic       inValid,
  input  logic [2:0] inOp,
  input  logic       dirHasMod,
  input  logic       dirHasShr,
  input  logic       respMatch,
  input  logic       outReady,
  output logic       cpuDone,
  output logic       inReady,
  output logic       outValid,
  output ctlStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_VICTIM = 3'd1,
    ST_REQ    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_DIRWB  = 3'd4
  } ctlSt_t;

  ctlSt_t st, nxt;
  logic   retWait;

  // directory command handling, shared by idle and wait
  function automatic void dirCmd(input logic [2:0] op, input logic hasMod,
                                 input logic hasShr, inout ctlStrobe_t s,
                                 inout ctlSt_t n);
    case (op)
      MSG_FETCH: if (hasMod) begin
        s.dirDown = 1'b1; s.dirCapture = 1'b1; n = ST_DIRWB;
      end
      MSG_FETCHINV: if (hasMod) begin
        s.dirKill = 1'b1; s.dirCapture = 1'b1; n = ST_DIRWB;
      end else if (hasShr) begin
        s.dirKill = 1'b1;
      end
      MSG_INV: if (hasShr) s.dirKill = 1'b1;
      default: ;
    endcase
  endfunction

  always_comb begin
    ctlStrobe_t s;
    ctlSt_t     n;
    s        = '0;
    n        = st;
    cpuDone  = 1'b0;
    inReady  = 1'b0;
    outValid = 1'b0;
    case (st)
      ST_IDLE: begin
        inReady = !(cpuValid && cpuHit);
        if (cpuValid && cpuHit) begin
          cpuDone = 1'b1;
          s.cpuWr = cpuWrite;
        end else if (inValid) begin
          dirCmd(inOp, dirHasMod, dirHasShr, s, n);
        end else if (cpuValid) begin
          s.launch = 1'b1;
          n = victimDirty ? ST_VICTIM : ST_REQ;
        end
      end
      ST_VICTIM: begin
        outValid = 1'b1;
        s.sendWb = 1'b1;
        if (outReady) n = ST_REQ;
      end
      ST_REQ: begin
        outValid = 1'b1;
        if (outReady) n = ST_WAIT;
      end
      ST_WAIT: begin
        inReady = 1'b1;
        if (inValid) begin
          if (inOp == MSG_DRESP) begin
            if (respMatch) begin
              s.fill = 1'b1;
              n = ST_IDLE;
            end
          end else begin
            dirCmd(inOp, dirHasMod, dirHasShr, s, n);
          end
        end
      end
      ST_DIRWB: begin
        outValid = 1'b1;
        s.sendWb = 1'b1;
        if (outReady) n = retWait ? ST_WAIT : ST_IDLE;
      end
      default: n = ST_IDLE;
    endcase
    strobe = s;
    nxt    = n;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      retWait <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt == ST_DIRWB && st != ST_DIRWB) retWait <= (st == ST_WAIT);
    end
  end

  AST_STALL_UNTIL_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WAIT && !(inValid && inOp == MSG_DRESP && respMatch)) |=> !cpuDone) // R8
    else $error("completion without matching response");

endmodule

// File: rtl/cc_msi_ctrl.sv
module cc_msi_ctrl
  import cc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              outValid,
  input  logic              outReady,
  output logic [2:0]        outOp,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inOp,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData
);

  ctlStrobe_t strobe;
  logic cpuHit, victimDirty, dirHasMod, dirHasShr, respMatch;

  cc_control u_ctl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuHit(cpuHit), .victimDirty(victimDirty),
    .inValid(inValid), .inOp(inOp),
    .dirHasMod(dirHasMod), .dirHasShr(dirHasShr), .respMatch(respMatch),
    .outReady(outReady),
    .cpuDone(cpuDone), .inReady(inReady), .outValid(outValid),
    .strobe(strobe)
  );

  cc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .inAddr(inAddr), .inData(inData),
    .strobe(strobe),
    .cpuHit(cpuHit), .victimDirty(victimDirty),
    .dirHasMod(dirHasMod), .dirHasShr(dirHasShr), .respMatch(respMatch),
    .cpuRdata(cpuRdata),
    .outOp(outOp), .outAddr(outAddr), .outData(outData)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outOp) && $stable(outAddr) && $stable(outData))) // R10
    else $error("outgoing message changed while stalled");

  AST_OUT_OP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outOp == MSG_RDREQ || outOp == MSG_WRREQ || outOp == MSG_UPGR || outOp == MSG_WBACK)) // R10
    else $error("illegal outgoing opcode");

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuValid) // R9
    else $error("completion without a processor request");

endmodule

// File: tb/sim_cc_msi_ctrl.sv
`timescale 1ns/100ps
module sim_cc_msi_ctrl;

  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [2:0] OP_DRESP = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2, OP_UPG = 3'd3,
                         OP_WB = 3'd4, OP_FETCH = 3'd5, OP_FINV = 3'd6, OP_INV = 3'd7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic cpuDone;
  logic [DW-1:0] cpuRdata;
  logic outValid, outReady = 1'b1;
  logic [2:0] outOp;
  logic [AW-1:0] outAddr;
  logic [DW-1:0] outData;
  logic inValid = 1'b0, inReady;
  logic [2:0] inOp = '0;
  logic [AW-1:0] inAddr = '0;
  logic [DW-1:0] inData = '0;

  always #2.5 clk = ~clk;

  cc_msi_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(8)) u0 (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .outValid(outValid), .outReady(outReady), .outOp(outOp), .outAddr(outAddr), .outData(outData),
    .inValid(inValid), .inReady(inReady), .inOp(inOp), .inAddr(inAddr), .inData(inData)
  );

  int nChecks = 0;
  int nFails  = 0;

  // scoreboard of expected outgoing messages
  logic [2:0]    expOp[$];
  logic [AW-1:0] expAddr[$];
  logic [DW-1:0] expData[$];
  bit            expChk[$];
  string         expReq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit chk, input string req);
    expOp.push_back(op); expAddr.push_back(a); expData.push_back(d);
    expChk.push_back(chk); expReq.push_back(req);
  endtask

  // monitor: compares each accepted outgoing message with the queue head
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rstN && outValid && outReady) begin
        if (expOp.size() == 0) begin
          check(1'b0, "R7", "unexpected outgoing message op/addr", {17'd0, outOp, outAddr}, 32'd0);
        end else begin
          logic [2:0] eo; logic [AW-1:0] ea; logic [DW-1:0] ed; bit ec; string er;
          eo = expOp.pop_front(); ea = expAddr.pop_front(); ed = expData.pop_front();
          ec = expChk.pop_front(); er = expReq.pop_front();
          check(outOp == eo, er, "message opcode", {29'd0, outOp}, {29'd0, eo});
          check(outAddr == ea, er, "message address", {20'd0, outAddr}, {20'd0, ea});
          if (ec) check(outData == ed, er, "writeback data", outData, ed);
        end
      end
    end
  end

  task automatic waitQEmpty(input string req);
    int n = 0;
    while (expOp.size() != 0 && n < 60) begin
      @(negedge clk); #2; n++;
    end
    check(expOp.size() == 0, req, "expected messages seen", expOp.size(), 0);
  endtask

  task automatic sendMsg(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    inValid = 1'b1; inOp = op; inAddr = a; inData = d;
    #2;
    while (!inReady) begin @(negedge clk); #2; end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!cpuDone && n < 60) begin @(negedge clk); #2; n++; end
    check(cpuDone, req, "request completed", {31'd0, cpuDone}, 32'd1);
  endtask

  // processor access; for a miss the expected messages are pushed by the caller
  task automatic doAccess(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input bit miss, input logic [DW-1:0] respD,
                          input bit chkRd, input logic [DW-1:0] expRd,
                          input bit wrongFirst, input string req);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    #2;
    if (!miss) begin
      check(cpuDone, req, "hit completes in the request cycle", {31'd0, cpuDone}, 32'd1);
    end else begin
      waitQEmpty(req);
      check(!cpuDone, "R8", "processor stalled while waiting", {31'd0, cpuDone}, 32'd0);
      if (wrongFirst) begin
        sendMsg(OP_DRESP, a ^ 12'h100, 32'hDEAD_BEEF);
        repeat (2) @(negedge clk);
        #2;
        check(!cpuDone, "R8", "response for other address ignored", {31'd0, cpuDone}, 32'd0);
      end
      sendMsg(OP_DRESP, a, respD);
      #2;
      waitDone(req);
    end
    if (chkRd) check(cpuRdata == expRd, req, "read data", cpuRdata, expRd);
    @(negedge clk);
    cpuValid = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R12 reset state
    check(!outValid, "R12", "outgoing idle after reset", {31'd0, outValid}, 32'd0);
    check(!cpuDone, "R12", "no completion after reset", {31'd0, cpuDone}, 32'd0);
    check(inReady, "R12", "incoming ready after reset", {31'd0, inReady}, 32'd1);

    // R1 read miss with a stray response first (R8)
    pushExp(OP_RD, 12'h010, 0, 0, "R1");
    doAccess(0, 12'h010, 0, 1, 32'hAAAA_0010, 1, 32'hAAAA_0010, 1, "R1");
    // R9 read hit
    doAccess(0, 12'h010, 0, 0, 0, 1, 32'hAAAA_0010, 0, "R9");
    // R2 write to a Shared line: upgrade
    pushExp(OP_UPG, 12'h010, 0, 0, "R2");
    doAccess(1, 12'h010, 32'h0000_0011, 1, 32'hAAAA_0010, 0, 0, 0, "R2");
    doAccess(0, 12'h010, 0, 0, 0, 1, 32'h0000_0011, 0, "R2");
    // R9 write hit on Modified, no message
    doAccess(1, 12'h010, 32'h0000_0022, 0, 0, 0, 0, 0, "R9");
    // R4 dirty victim written back before the new request
    pushExp(OP_WB, 12'h010, 32'h0000_0022, 1, "R4");
    pushExp(OP_RD, 12'h018, 0, 0, "R4");
    doAccess(0, 12'h018, 0, 1, 32'hBBBB_0018, 1, 32'hBBBB_0018, 0, "R4");
    // R4 clean victim dropped silently
    pushExp(OP_RD, 12'h020, 0, 0, "R4");
    doAccess(0, 12'h020, 0, 1, 32'hCCCC_0020, 1, 32'hCCCC_0020, 0, "R4");
    // R3 write miss
    pushExp(OP_WR, 12'h003, 0, 0, "R3");
    doAccess(1, 12'h003, 32'h0000_0033, 1, 32'hCCCC_0003, 0, 0, 0, "R3");
    doAccess(0, 12'h003, 0, 0, 0, 1, 32'h0000_0033, 0, "R3");
    // R5 downgrade of a Modified line
    pushExp(OP_WB, 12'h003, 32'h0000_0033, 1, "R5");
    sendMsg(OP_FETCH, 12'h003, 0);
    waitQEmpty("R5");
    doAccess(0, 12'h003, 0, 0, 0, 1, 32'h0000_0033, 0, "R5");
    pushExp(OP_UPG, 12'h003, 0, 0, "R5");
    doAccess(1, 12'h003, 32'h0000_0044, 1, 32'h0000_0033, 0, 0, 0, "R5");
    // R6 downgrade-and-drop
    pushExp(OP_WB, 12'h003, 32'h0000_0044, 1, "R6");
    sendMsg(OP_FINV, 12'h003, 0);
    waitQEmpty("R6");
    pushExp(OP_RD, 12'h003, 0, 0, "R6");
    doAccess(0, 12'h003, 0, 1, 32'h0000_0044, 1, 32'h0000_0044, 0, "R6");
    // R7 invalidate of a Shared line
    sendMsg(OP_INV, 12'h003, 0);
    pushExp(OP_RD, 12'h003, 0, 0, "R7");
    doAccess(0, 12'h003, 0, 1, 32'h0000_0055, 1, 32'h0000_0055, 0, "R7");
    // R7 commands with no effect
    sendMsg(OP_FETCH, 12'h003, 0);
    sendMsg(OP_FETCH, 12'h00B, 0);
    sendMsg(OP_INV, 12'h00B, 0);
    repeat (3) @(negedge clk);
    #2;
    check(!outValid, "R7", "no message for ineligible commands", {31'd0, outValid}, 32'd0);
    doAccess(0, 12'h003, 0, 0, 0, 1, 32'h0000_0055, 0, "R7");

    // R11 directory command serviced during a pending miss
    pushExp(OP_WR, 12'h005, 0, 0, "R3");
    doAccess(1, 12'h005, 32'h0000_0066, 1, 32'h0000_0050, 0, 0, 0, "R3");
    pushExp(OP_RD, 12'h006, 0, 0, "R11");
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuAddr = 12'h006;
    #2;
    waitQEmpty("R11");
    pushExp(OP_WB, 12'h005, 32'h0000_0066, 1, "R11");
    sendMsg(OP_FETCH, 12'h005, 0);
    waitQEmpty("R11");
    check(!cpuDone, "R11", "still waiting after serviced command", {31'd0, cpuDone}, 32'd0);
    sendMsg(OP_DRESP, 12'h006, 32'h0000_0060);
    #2;
    waitDone("R11");
    check(cpuRdata == 32'h0000_0060, "R11", "read data after interleaved command", cpuRdata, 32'h0000_0060);
    @(negedge clk);
    cpuValid = 1'b0;
    doAccess(0, 12'h005, 0, 0, 0, 1, 32'h0000_0066, 0, "R5");

    // R10 outgoing message held while not accepted
    outReady = 1'b0;
    pushExp(OP_RD, 12'h007, 0, 0, "R10");
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuAddr = 12'h007;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      check(outValid && outOp == OP_RD && outAddr == 12'h007, "R10", "stalled message held",
            {19'd0, outValid, outOp, outAddr[8:0]}, {19'd0, 1'b1, OP_RD, 9'h007});
    end
    @(negedge clk);
    outReady = 1'b1;
    #2;
    waitQEmpty("R10");
    sendMsg(OP_DRESP, 12'h007, 32'h0000_0077);
    #2;
    waitDone("R10");
    check(cpuRdata == 32'h0000_0077, "R10", "read data after stall", cpuRdata, 32'h0000_0077);
    @(negedge clk);
    cpuValid = 1'b0;

    repeat (4) @(negedge clk);
    check(expOp.size() == 0, "R4", "no leftover expected messages", expOp.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule